// File: doc/BRIEF.md
# Weight-Sum Match Verifier

This block sits behind a group of sub-pattern detection units. When a unit sees what may be the end of a signature, it sends a candidate. A candidate has three parts: the accumulated weight tuple, a base and an offset that together address a slot, and a small hash-select code. The block checks each candidate against two tables and reports a verdict for it.

The primary table is addressed by base plus offset, wrapped to the table depth. The smaller collision table is addressed by an XOR/ADD hash of the candidate's own tuple. This hash resolves signatures whose tails land on the same primary slot. Both tables are read in the same cycle. A candidate is confirmed when a valid entry in either table holds exactly the same tuple. The primary table wins when both match.

Each detection unit has its own short queue, so several units can report in the same cycle. A round-robin arbiter drains one queue entry per cycle. A host write port loads either table while lookups continue.

Top module: `pv_verify`

## Requirements
- R1: After reset, `res_valid_o` is low, every `cand_ready_o` bit is high, and every entry of both tables is invalid, so any lookup is rejected.
- R2: Each unit has a candidate queue of `FIFO_DEPTH` entries. `cand_ready_o[u]` is low exactly while that queue is full. A candidate is taken only in a cycle where valid and ready are both high. Each accepted candidate produces exactly one verdict, and no other verdicts appear.
- R3: The primary table slot is (`base` + `off`) mod `PT_DEPTH`. A valid entry at that slot confirms the candidate when all `NUM_W` components are equal. Component k of a tuple sits at bits [k*SUM_W +: SUM_W]. A confirmed primary hit gives `res_hit_o`=1 and `res_coll_o`=0.
- R4: If any single component differs from the stored entry, that table does not confirm the candidate.
- R5: The collision slot is computed as follows.
  - Let r = hsel mod `NUM_W`, and let v_k = component (k+r) mod `NUM_W`.
  - Start with a = v_0. For k = 1 to `NUM_W`-1, take a = a + v_k (mod 2^SUM_W) when k is odd, and a = a XOR v_k when k is even.
  - Slot bit j is the XOR of all bits i of a with i mod CAW = j.
  
  A valid matching entry there gives `res_hit_o`=1 and `res_coll_o`=1, but only when the primary table misses.
- R6: An entry written with its valid bit at 0 never confirms anything.
- R7: A candidate tuple of all zeros is always rejected, even against a valid all-zero entry.
- R8: When several queues hold entries, one is served per cycle. Service goes in rising unit index, wrapping around, and starts after the unit served last. After reset, unit 0 is served first. Each unit's candidates are judged in arrival order.
- R9: A candidate accepted at an idle edge k is dequeued at edge k+1. Its verdict is visible with `res_valid_o` high for exactly the one cycle after edge k+2.
- R10: A host write and a lookup read can hit the same slot in the same cycle. In that case the lookup compares against the data held before the write.
- R11: `res_unit_o` gives the index of the unit whose candidate produced the verdict.
- R12: For host writes, `hw_tbl_i`=0 selects the primary table and `hw_tbl_i`=1 selects the collision table. The collision table uses the low CAW bits of `hw_addr_i`. `hw_valid_i` is stored as the entry's valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | NUM_UNITS | Candidate offered, one bit per unit |
| cand_ready_o | output | NUM_UNITS | Queue has room, one bit per unit |
| cand_tuple_i | input | NUM_UNITS*NUM_W*SUM_W | Candidate weight tuples, unit u at slice u |
| cand_base_i | input | NUM_UNITS*PAW | Tail base address per unit |
| cand_off_i | input | NUM_UNITS*PAW | Tail offset per unit |
| cand_hsel_i | input | NUM_UNITS*HSEL_W | Hash component order select per unit |
| hw_en_i | input | 1 | Host table write strobe |
| hw_tbl_i | input | 1 | Target table: 0 primary, 1 collision |
| hw_addr_i | input | PAW | Write slot |
| hw_valid_i | input | 1 | Valid bit stored with the entry |
| hw_tuple_i | input | NUM_W*SUM_W | Summation tuple to store |
| res_valid_o | output | 1 | One-cycle verdict strobe |
| res_hit_o | output | 1 | Candidate confirmed |
| res_coll_o | output | 1 | Confirmation came from the collision table |
| res_unit_o | output | UIW | Unit index of the judged candidate |

## Verification
The checker watches several properties on every cycle:
- the grant is one-hot or idle, and no grant goes to an empty queue;
- every grant yields a verdict exactly two edges later, carrying the granted unit index;
- a collision flag never appears without a hit;
- a zero tuple never produces a hit.

Other behaviour depends on table contents and on the order of concurrent traffic, so only the bench scenarios can show it:
- slot arithmetic that wraps past the table depth;
- the component-order effect of the hash select;
- primary-over-collision priority;
- old-data reads during a same-slot write;
- rotation order across units;
- back-pressure with no lost or spurious verdicts.

// File: rtl/pv_pkg.sv
package pv_pkg;
  typedef enum logic {
    TBL_PRI = 1'b0,
    TBL_COL = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/pv_fifo.sv
module pv_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end
endmodule

// File: rtl/pv_rr_arb.sv
module pv_rr_arb #(
  parameter int N  = 3,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] last_q;
  logic          found;

  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!found && req_i[c]) begin
        gnt_o[c] = 1'b1;
        idx_o    = IW'(c);
        found    = 1'b1;
      end
    end
  end

  // reset points at the top index so unit 0 wins first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= IW'(N - 1);
    else if (|req_i) last_q <= idx_o;
  end
endmodule

// File: rtl/pv_hash.sv
module pv_hash #(
  parameter int M  = 3,
  parameter int SW = 10,
  parameter int HW = 2,
  parameter int AW = 3
) (
  input  logic [M*SW-1:0] tuple_i,
  input  logic [HW-1:0]   hsel_i,
  output logic [AW-1:0]   addr_o
);
  logic [SW-1:0] acc;
  int            rot;

  always_comb begin
    rot = int'(hsel_i) % M;
    acc = tuple_i[rot*SW +: SW];
    for (int k = 1; k < M; k++) begin
      if (k % 2 == 1) acc = acc + tuple_i[((k + rot) % M)*SW +: SW];
      else            acc = acc ^ tuple_i[((k + rot) % M)*SW +: SW];
    end
    addr_o = '0;
    for (int i = 0; i < SW; i++) addr_o[i % AW] = addr_o[i % AW] ^ acc[i];
  end
endmodule

// File: rtl/pv_table.sv
module pv_table #(
  parameter int DEPTH = 16,
  parameter int W     = 30,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wvalid_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rvalid_o,
  output logic [W-1:0]  rdata_o
);
  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= vld_q[raddr_i];
      if (we_i) vld_q[waddr_i] <= wvalid_i;
    end
  end

  // read samples pre-write contents on a same-slot collision
  always_ff @(posedge clk_i) begin
    rdata_o <= mem[raddr_i];
    if (we_i) mem[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/pv_verify.sv
module pv_verify
  import pv_pkg::*;
#(
  parameter int NUM_UNITS  = 3,
  parameter int NUM_W      = 3,
  parameter int SUM_W      = 10,
  parameter int PT_DEPTH   = 16,
  parameter int CT_DEPTH   = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int HSEL_W     = 2,
  localparam int TUP_W     = NUM_W * SUM_W,
  localparam int PAW       = $clog2(PT_DEPTH),
  localparam int CAW       = $clog2(CT_DEPTH),
  localparam int UIW       = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_UNITS-1:0]          cand_valid_i,
  output logic [NUM_UNITS-1:0]          cand_ready_o,
  input  logic [NUM_UNITS*TUP_W-1:0]    cand_tuple_i,
  input  logic [NUM_UNITS*PAW-1:0]      cand_base_i,
  input  logic [NUM_UNITS*PAW-1:0]      cand_off_i,
  input  logic [NUM_UNITS*HSEL_W-1:0]   cand_hsel_i,
  input  logic                          hw_en_i,
  input  logic                          hw_tbl_i,
  input  logic [PAW-1:0]                hw_addr_i,
  input  logic                          hw_valid_i,
  input  logic [TUP_W-1:0]              hw_tuple_i,
  output logic                          res_valid_o,
  output logic                          res_hit_o,
  output logic                          res_coll_o,
  output logic [UIW-1:0]                res_unit_o
);
  localparam int ENT_W = HSEL_W + PAW + TUP_W;

  logic [ENT_W-1:0]     ent_in [NUM_UNITS];
  logic [ENT_W-1:0]     head   [NUM_UNITS];
  logic [NUM_UNITS-1:0] fifo_full, fifo_empty, fifo_req, gnt;
  logic [UIW-1:0]       gnt_idx;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [PAW-1:0] slot;
    // PAW-bit add wraps modulo PT_DEPTH
    assign slot = cand_base_i[u*PAW +: PAW] + cand_off_i[u*PAW +: PAW];
    assign ent_in[u] = {cand_hsel_i[u*HSEL_W +: HSEL_W], slot,
                        cand_tuple_i[u*TUP_W +: TUP_W]};
    assign cand_ready_o[u] = ~fifo_full[u];
    assign fifo_req[u]     = ~fifo_empty[u];

    pv_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (cand_valid_i[u] & ~fifo_full[u]),
      .din_i   (ent_in[u]),
      .pop_i   (gnt[u]),
      .dout_o  (head[u]),
      .full_o  (fifo_full[u]),
      .empty_o (fifo_empty[u])
    );
  end

  pv_rr_arb #(.N(NUM_UNITS), .IW(UIW)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (fifo_req),
    .gnt_o  (gnt),
    .idx_o  (gnt_idx)
  );

  logic [ENT_W-1:0]  sel_ent;
  logic [TUP_W-1:0]  sel_tuple;
  logic [PAW-1:0]    sel_slot;
  logic [HSEL_W-1:0] sel_hsel;
  logic [CAW-1:0]    col_raddr;

  assign sel_ent   = head[gnt_idx];
  assign sel_tuple = sel_ent[TUP_W-1:0];
  assign sel_slot  = sel_ent[TUP_W +: PAW];
  assign sel_hsel  = sel_ent[TUP_W+PAW +: HSEL_W];

  pv_hash #(.M(NUM_W), .SW(SUM_W), .HW(HSEL_W), .AW(CAW)) u_hash (
    .tuple_i (sel_tuple),
    .hsel_i  (sel_hsel),
    .addr_o  (col_raddr)
  );

  logic             pri_we, col_we, pri_rv, col_rv;
  logic [TUP_W-1:0] pri_rd, col_rd;

  assign pri_we = hw_en_i && (tbl_sel_e'(hw_tbl_i) == TBL_PRI);
  assign col_we = hw_en_i && (tbl_sel_e'(hw_tbl_i) == TBL_COL);

  pv_table #(.DEPTH(PT_DEPTH), .W(TUP_W), .AW(PAW)) u_pri (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (pri_we),
    .waddr_i  (hw_addr_i),
    .wvalid_i (hw_valid_i),
    .wdata_i  (hw_tuple_i),
    .raddr_i  (sel_slot),
    .rvalid_o (pri_rv),
    .rdata_o  (pri_rd)
  );

  pv_table #(.DEPTH(CT_DEPTH), .W(TUP_W), .AW(CAW)) u_col (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (col_we),
    .waddr_i  (hw_addr_i[CAW-1:0]),
    .wvalid_i (hw_valid_i),
    .wdata_i  (hw_tuple_i),
    .raddr_i  (col_raddr),
    .rvalid_o (col_rv),
    .rdata_o  (col_rd)
  );

  logic             s1_valid;
  logic [TUP_W-1:0] s1_tuple;
  logic [UIW-1:0]   s1_unit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_tuple <= '0;
      s1_unit  <= '0;
    end else begin
      s1_valid <= |gnt;
      s1_tuple <= sel_tuple;
      s1_unit  <= gnt_idx;
    end
  end

  logic nz, pri_hit, col_hit;
  assign nz      = |s1_tuple;
  assign pri_hit = pri_rv && (pri_rd == s1_tuple) && nz;
  assign col_hit = col_rv && (col_rd == s1_tuple) && nz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_coll_o  <= 1'b0;
      res_unit_o  <= '0;
    end else begin
      res_valid_o <= s1_valid;
      res_hit_o   <= s1_valid && (pri_hit || col_hit);
      res_coll_o  <= s1_valid && !pri_hit && col_hit;
      res_unit_o  <= s1_unit;
    end
  end
endmodule

// File: rtl/pv_chk.sv
module pv_chk #(
  parameter int NU    = 3,
  parameter int TUP_W = 30,
  parameter int UIW   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NU-1:0]    gnt_i,
  input logic [UIW-1:0]   gnt_idx_i,
  input logic [NU-1:0]    fifo_empty_i,
  input logic             s1_valid_i,
  input logic [TUP_W-1:0] s1_tuple_i,
  input logic             res_valid_i,
  input logic             res_hit_i,
  input logic             res_coll_i,
  input logic [UIW-1:0]   res_unit_i
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  // R8
  grant_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i & fifo_empty_i) == '0);

  // R9
  verdict_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_i) |-> ##2 res_valid_i);

  // R9
  verdict_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> $past(|gnt_i, 2));

  // R11
  unit_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i |-> (res_unit_i == $past(gnt_idx_i, 2)) && (int'(res_unit_i) < NU));

  // R5
  coll_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_coll_i |-> (res_hit_i && res_valid_i));

  // R7
  zero_tuple_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_i && (s1_tuple_i == '0)) |=> !res_hit_i);
endmodule

bind pv_verify pv_chk #(.NU(NUM_UNITS), .TUP_W(TUP_W), .UIW(UIW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gnt_i        (gnt),
  .gnt_idx_i    (gnt_idx),
  .fifo_empty_i (fifo_empty),
  .s1_valid_i   (s1_valid),
  .s1_tuple_i   (s1_tuple),
  .res_valid_i  (res_valid_o),
  .res_hit_i    (res_hit_o),
  .res_coll_i   (res_coll_o),
  .res_unit_i   (res_unit_o)
);

// File: tb/sim_pv_verify.sv
module sim_pv_verify;
  localparam int NU = 3, M = 3, SW = 10, TW = 30;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    cand_valid = '0;
  logic [2:0]    cand_ready;
  logic [89:0]   cand_tuple = '0;
  logic [11:0]   cand_base = '0, cand_off = '0;
  logic [5:0]    cand_hsel = '0;
  logic          hw_en = 0, hw_tbl = 0, hw_valid = 0;
  logic [3:0]    hw_addr = '0;
  logic [TW-1:0] hw_tuple = '0;
  logic          res_valid, res_hit, res_coll;
  logic [1:0]    res_unit;

  always #10 clk = ~clk;

  pv_verify u0 (
    .clk_i(clk), .rst_ni(rst_n), .cand_valid_i(cand_valid), .cand_ready_o(cand_ready),
    .cand_tuple_i(cand_tuple), .cand_base_i(cand_base), .cand_off_i(cand_off),
    .cand_hsel_i(cand_hsel), .hw_en_i(hw_en), .hw_tbl_i(hw_tbl), .hw_addr_i(hw_addr),
    .hw_valid_i(hw_valid), .hw_tuple_i(hw_tuple), .res_valid_o(res_valid),
    .res_hit_o(res_hit), .res_coll_o(res_coll), .res_unit_o(res_unit)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, acc_cyc = 0, last_unit = 2;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic          pt_v [16];
  logic [TW-1:0] pt_t [16];
  logic          ct_v [8];
  logic [TW-1:0] ct_t [8];

  logic [1:0] eq_v   [NU][256];
  string      eq_tag [NU][256];
  int         hd [NU], tl [NU];
  int         rr_log [8];
  int         rr_n = 0;
  bit         rr_rec = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] hash_f(logic [TW-1:0] t, logic [1:0] hs);
    int r;
    logic [SW-1:0] v [3];
    logic [SW-1:0] a;
    logic [2:0] h;
    r = int'(hs) % M;
    for (int k = 0; k < 3; k++) v[k] = t[((k + r) % 3)*SW +: SW];
    a = v[0] + v[1];
    a = a ^ v[2];
    h = '0;
    for (int i = 0; i < SW; i++) h[i % 3] ^= a[i];
    return h;
  endfunction

  function automatic logic [1:0] model(logic [TW-1:0] t, logic [3:0] b, logic [3:0] o,
                                       logic [1:0] hs);
    logic [3:0] pa;
    logic [2:0] ca;
    if (t == '0) return 2'b00;
    pa = b + o;
    if (pt_v[pa] && pt_t[pa] == t) return 2'b10;
    ca = hash_f(t, hs);
    if (ct_v[ca] && ct_t[ca] == t) return 2'b11;
    return 2'b00;
  endfunction

  task automatic enq(int u, logic [1:0] v, string tag);
    eq_v[u][tl[u] & 255]   = v;
    eq_tag[u][tl[u] & 255] = tag;
    tl[u]++;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      int u;
      u = int'(res_unit);
      last_unit = u;
      if (rr_rec && rr_n < 8) begin rr_log[rr_n] = u; rr_n++; end
      if (u >= NU || hd[u] == tl[u]) chk(0, "R2", "spurious verdict unit", u, -1);
      else begin
        chk({res_hit, res_coll} == eq_v[u][hd[u] & 255], eq_tag[u][hd[u] & 255],
            "verdict {hit,coll}", int'({res_hit, res_coll}), int'(eq_v[u][hd[u] & 255]));
        hd[u]++;
      end
    end
  end

  task automatic hw_wr(bit tbl, int a, bit v, logic [TW-1:0] t);
    @(negedge clk);
    hw_en = 1; hw_tbl = tbl; hw_addr = 4'(a); hw_valid = v; hw_tuple = t;
    @(posedge clk);
    #1 hw_en = 0;
    if (!tbl) begin pt_v[a & 15] = v; pt_t[a & 15] = t; end
    else      begin ct_v[a & 7]  = v; ct_t[a & 7]  = t; end
  endtask

  task automatic send(int u, logic [TW-1:0] t, logic [3:0] b, logic [3:0] o,
                      logic [1:0] hs, logic [1:0] exp, string tag);
    @(negedge clk);
    cand_valid[u] = 1;
    cand_tuple[u*TW +: TW] = t;
    cand_base[u*4 +: 4] = b; cand_off[u*4 +: 4] = o; cand_hsel[u*2 +: 2] = hs;
    while (!cand_ready[u]) @(negedge clk);
    enq(u, exp, tag);
    @(posedge clk);
    #1 acc_cyc = cyc;
    cand_valid[u] = 0;
  endtask

  function automatic logic [TW-1:0] mk(int a, int b, int c);
    return {SW'(c), SW'(b), SW'(a)};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      chk(0, "R9", "watchdog expired", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] ta, tc;
    logic [1:0] hs_other;
    int start;
    bit saw_low;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin pt_v[i] = 0; pt_t[i] = '0; end
    for (int i = 0; i < 8; i++)  begin ct_v[i] = 0; ct_t[i] = '0; end
    for (int u = 0; u < NU; u++) begin hd[u] = 0; tl[u] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(res_valid == 0, "R1", "res_valid after reset", res_valid, 0);
    chk(cand_ready == 3'b111, "R1", "ready after reset", cand_ready, 7);
    send(0, mk(1, 2, 3), 4'd0, 4'd0, 2'd0, 2'b00, "R1");
    idle(4);

    ta = mk(17, 400, 9);
    hw_wr(0, 5, 1, ta);
    // R12 R3: slot = base+off, incl. wrap
    send(1, ta, 4'd2, 4'd3, 2'd0, 2'b10, "R3");
    send(2, ta, 4'd12, 4'd9, 2'd3, 2'b10, "R3");
    send(0, ta, 4'd2, 4'd4, 2'd0, 2'b00, "R3");
    // R4: single component mismatch
    send(0, mk(17, 401, 9), 4'd5, 4'd0, 2'd0, 2'b00, "R4");
    send(1, mk(17, 400, 8), 4'd5, 4'd0, 2'd0, 2'b00, "R4");
    // R6: invalid entry
    hw_wr(0, 6, 0, mk(5, 5, 5));
    send(1, mk(5, 5, 5), 4'd6, 4'd0, 2'd0, 2'b00, "R6");
    hw_wr(0, 5, 0, ta);
    send(2, ta, 4'd5, 4'd0, 2'd0, 2'b00, "R6");
    // R7: zero tuple
    hw_wr(0, 7, 1, '0);
    send(0, '0, 4'd7, 4'd0, 2'd0, 2'b00, "R7");
    // R5: collision table, hash select, primary priority
    tc = mk(300, 45, 7);
    hw_wr(1, int'(hash_f(tc, 2'd1)), 1, tc);
    send(2, tc, 4'd0, 4'd9, 2'd1, 2'b11, "R5");
    hs_other = (hash_f(tc, 2'd0) != hash_f(tc, 2'd1)) ? 2'd0 : 2'd2;
    send(2, tc, 4'd0, 4'd9, hs_other,
         (hash_f(tc, hs_other) == hash_f(tc, 2'd1)) ? 2'b11 : 2'b00, "R5");
    hw_wr(0, 9, 1, tc);
    send(1, tc, 4'd4, 4'd5, 2'd1, 2'b10, "R5");
    idle(6);

    // R9: fixed latency, one-cycle pulse; R11 unit index
    send(1, tc, 4'd9, 4'd0, 2'd0, 2'b10, "R9");
    start = acc_cyc;
    @(negedge clk);
    chk(res_valid == 0, "R9", "early verdict", cyc - start, 2);
    @(negedge clk);
    chk(res_valid == 0, "R9", "early verdict", cyc - start, 2);
    @(negedge clk);
    chk(res_valid == 1 && cyc == start + 2, "R9", "verdict cycle", cyc - start, 2);
    chk(res_unit == 2'd1, "R11", "unit index", res_unit, 1);
    @(negedge clk);
    chk(res_valid == 0, "R9", "pulse width", res_valid, 0);
    idle(4);

    // R10: same-slot write during lookup returns old data
    hw_wr(0, 11, 1, ta);
    idle(3);
    send(0, ta, 4'd11, 4'd0, 2'd0, 2'b10, "R10");
    hw_wr(0, 11, 1, mk(1, 1, 1));
    send(0, ta, 4'd11, 4'd0, 2'd0, 2'b00, "R10");
    send(0, mk(1, 1, 1), 4'd11, 4'd0, 2'd0, 2'b10, "R10");
    idle(6);

    // R8: rotation across three units, two candidates each
    start = last_unit;
    rr_n = 0; rr_rec = 1;
    @(negedge clk);
    for (int u = 0; u < NU; u++) begin
      cand_valid[u] = 1; cand_tuple[u*TW +: TW] = mk(u + 1, 0, 0);
      cand_base[u*4 +: 4] = 4'd0; cand_off[u*4 +: 4] = 4'd1; cand_hsel[u*2 +: 2] = 0;
      enq(u, model(mk(u + 1, 0, 0), 4'd0, 4'd1, 2'd0), "R8");
    end
    @(posedge clk);
    #1;
    for (int u = 0; u < NU; u++) begin
      cand_tuple[u*TW +: TW] = mk(u + 4, 0, 0);
      enq(u, model(mk(u + 4, 0, 0), 4'd0, 4'd1, 2'd0), "R8");
    end
    @(posedge clk);
    #1 cand_valid = '0;
    idle(10);
    rr_rec = 0;
    chk(rr_n == 6, "R8", "verdict count", rr_n, 6);
    for (int i = 0; i < 6; i++)
      chk(rr_log[i] == (start + 1 + i) % NU, "R8", "service order", rr_log[i],
          (start + 1 + i) % NU);

    // R2: sustained offer from all units forces back-pressure
    saw_low = 0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      for (int u = 0; u < NU; u++) begin
        logic [TW-1:0] t;
        t = mk($urandom % 8, $urandom % 8, 1);
        cand_valid[u] = 1; cand_tuple[u*TW +: TW] = t;
        cand_base[u*4 +: 4] = 4'($urandom); cand_off[u*4 +: 4] = 4'($urandom);
        cand_hsel[u*2 +: 2] = 2'($urandom);
        if (cand_ready[u])
          enq(u, model(t, cand_base[u*4 +: 4], cand_off[u*4 +: 4], cand_hsel[u*2 +: 2]), "R2");
        else saw_low = 1;
      end
    end
    @(negedge clk);
    cand_valid = '0;
    idle(20);
    chk(saw_low, "R2", "ready dropped when queue full", saw_low, 1);

    // random phase: R3 R5 R4 against reloaded tables
    for (int i = 0; i < 16; i++)
      hw_wr(0, i, ($urandom % 4) != 0, mk($urandom % 8, $urandom % 8, $urandom % 8));
    for (int i = 0; i < 8; i++)
      hw_wr(1, i, ($urandom % 4) != 0, mk($urandom % 8, $urandom % 8, $urandom % 8));
    for (int n = 0; n < 150; n++) begin
      int kind, u;
      logic [TW-1:0] t;
      logic [3:0] b, o;
      logic [1:0] hs;
      kind = $urandom % 10; u = $urandom % NU;
      b = 4'($urandom); hs = 2'($urandom);
      if (kind < 5) begin
        int a;
        a = $urandom % 16; t = pt_t[a]; o = 4'(a) - b;
      end else if (kind < 8) begin
        int c;
        c = $urandom % 8; t = ct_t[c]; o = 4'($urandom);
        for (int h = 0; h < 4; h++) if (hash_f(t, 2'(h)) == 3'(c)) hs = 2'(h);
      end else begin
        t = mk($urandom % 4, $urandom % 4, $urandom % 4); o = 4'($urandom);
      end
      send(u, t, b, o, hs, model(t, b, o, hs), "R3");
    end
    idle(20);
    for (int u = 0; u < NU; u++)
      chk(hd[u] == tl[u], "R2", "verdicts missing for unit", tl[u] - hd[u], 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule